// File: doc/BRIEF.md
# Sticky Error Status and First-Error Capture

This block gathers error events reported by a request/reply packet unit. Each of eleven error kinds owns one sticky status bit. Once a bit is set, it stays set until software clears it. Any set bit raises an interrupt request. The packet parser raises single-cycle pulses, one line per error kind. With each pulse it presents the offending packet's header fields, its address and an optional data flit.

The block holds one first-error record: the header, the address, the data, an error type code, a valid flag and an overrun flag. Later errors only mark the record as overrun. They do not replace it. The clock-drop kind sets its status bit and never touches the record.

Software uses a simple register port:
- It can read the status bits.
- It can clear any subset of them through a write-one-to-clear register.
- It can load the status and capture registers directly. This lets it inject errors and re-arm the record.

Top module: `errstat_capture`

## Requirements
- R1: Register offsets are 0 status, 1 clear, 2 header, 3 address, 4 data. Status bit i (i = 0..10) is set the cycle after `err_pulse[i]` is high. The bit order is: request bad command, reply bad command, request short, reply short, request long, reply long, request bad data, reply bad data, request bad address, request bad invalidate, clock drop.
- R2: Status bits are sticky. Reading them does not clear them, and asserting `rst` does not clear them.
- R3: `irq` is high exactly when at least one status bit is set.
- R4: A write of mask M to the clear register clears every status bit whose bit in M is 1. All other status bits keep their value.
- R5: If a hardware pulse and a clear of the same bit happen in the same cycle, the bit ends up set.
- R6: A write to the status register loads its low 11 bits as the new status. Pulses in that cycle are ORed in. The write raises `irq` when the result is nonzero, and it does not change the capture registers.
- R7: A pulse of any kind except clock drop, arriving while valid is 0, does the following: it stores the header and address, sets valid, clears overrun, and records the type as the bit index. If several kinds pulse together, the lowest index is recorded.
- R8: A pulse of any kind except clock drop, arriving while valid is 1, sets overrun and leaves the stored fields unchanged.
- R9: A clock-drop pulse (bit 10) changes none of the header register fields: type, valid, overrun, command, supplemental and source.
- R10: The data register takes the flit only on a first capture (valid was 0) that carries a data flit (`err_has_data` = 1). Otherwise it keeps its value.
- R11: The header register layout is command 6:0, supplemental 18:8, source 30:20, type 35:32, overrun 40, valid 44. A write loads these fields, so writing 0 clears valid. Such a write sets no status bit.
- R12: Reset clears valid, overrun and type. Reading the clear register returns 0. The address register reads back a written 38-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (capture flags only) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| err_pulse | input | 11 | One pulse line per error kind |
| err_cmd | input | 7 | Offending packet command |
| err_suppl | input | 11 | Offending packet supplemental field |
| err_src | input | 11 | Offending packet source |
| err_addr | input | 38 | Offending packet address |
| err_has_data | input | 1 | Offending packet carries a data flit |
| err_data | input | 64 | Data flit |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is the same-cycle collision between a software clear and a hardware set of one bit. The stimulus drives the clear write and the pulse in the same cycle, then reads the status register back.

The record's overrun and clock-drop behaviour can only be seen through a sequence of steps:
1. A first error fills the record.
2. A second error sets overrun.
3. A clock drop arrives and must leave every field intact.
4. Software zeroes the header to re-arm the record.
5. A clock drop arrives while valid is 0 and must not arm it.

A reset in the middle of the run shows that the status bits survive while the flags drop.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
    parameter int N_ERR       = 11;
    parameter int CLKDROP_BIT = 10;
    parameter int CMD_W       = 7;
    parameter int SUPPL_W     = 11;
    parameter int SRC_W       = 11;
    parameter int TYPE_W      = 4;
    parameter int ADDR_W      = 38;
    parameter int DATA_W      = 64;
    parameter int REG_W       = 64;
    parameter int RADDR_W     = 3;

    localparam int CMD_LSB   = 0;
    localparam int SUPPL_LSB = 8;
    localparam int SRC_LSB   = 20;
    localparam int TYPE_LSB  = 32;
    localparam int OVR_BIT   = 40;
    localparam int VLD_BIT   = 44;

    localparam logic [N_ERR-1:0] DROP_ONLY    = N_ERR'(1) << CLKDROP_BIT;
    localparam logic [N_ERR-1:0] CAPTURE_MASK = ~DROP_ONLY;

    typedef enum logic [RADDR_W-1:0] {
        REG_STATUS = 3'd0,
        REG_CLEAR  = 3'd1,
        REG_HDR    = 3'd2,
        REG_ADDR   = 3'd3,
        REG_DATA   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [CMD_W-1:0]   cmd;
        logic [SUPPL_W-1:0] suppl;
        logic [SRC_W-1:0]   src;
    } pkt_hdr_t;

    typedef struct packed {
        logic              valid;
        logic              overrun;
        logic [TYPE_W-1:0] etype;
        pkt_hdr_t          hdr;
    } cap_hdr_t;

    function automatic logic [REG_W-1:0] pack_hdr(input cap_hdr_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[CMD_LSB   +: CMD_W]   = c.hdr.cmd;
        r[SUPPL_LSB +: SUPPL_W] = c.hdr.suppl;
        r[SRC_LSB   +: SRC_W]   = c.hdr.src;
        r[TYPE_LSB  +: TYPE_W]  = c.etype;
        r[OVR_BIT]              = c.overrun;
        r[VLD_BIT]              = c.valid;
        return r;
    endfunction

    function automatic cap_hdr_t unpack_hdr(input logic [REG_W-1:0] r);
        cap_hdr_t c;
        c.hdr.cmd   = r[CMD_LSB   +: CMD_W];
        c.hdr.suppl = r[SUPPL_LSB +: SUPPL_W];
        c.hdr.src   = r[SRC_LSB   +: SRC_W];
        c.etype     = r[TYPE_LSB  +: TYPE_W];
        c.overrun   = r[OVR_BIT];
        c.valid     = r[VLD_BIT];
        return c;
    endfunction

    function automatic logic [TYPE_W-1:0] lowest_index(input logic [N_ERR-1:0] v);
        logic [TYPE_W-1:0] idx;
        idx = '0;
        for (int i = N_ERR - 1; i >= 0; i--) begin
            if (v[i]) idx = TYPE_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/errcap_status.sv
module errcap_status
    import errcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ERR-1:0] hw_set,
    input  logic             sw_load,
    input  logic [N_ERR-1:0] sw_load_val,
    input  logic             sw_clr,
    input  logic [N_ERR-1:0] sw_clr_mask,
    output logic [N_ERR-1:0] status
);
    // Power-up value only; rst deliberately leaves these bits alone.
    logic [N_ERR-1:0] status_q = '0;
    logic [N_ERR-1:0] status_d;

    for (genvar i = 0; i < N_ERR; i++) begin : g_bit
        logic base;
        always_comb begin
            base = sw_load ? sw_load_val[i] : status_q[i];
            if (sw_clr && sw_clr_mask[i]) base = 1'b0;
            status_d[i] = base | hw_set[i];
        end
    end

    always_ff @(posedge clk) status_q <= status_d;

    assign status = status_q;

    assert_hw_set_sticks_R1: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((status_q & $past(hw_set)) == $past(hw_set)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!sw_load && !sw_clr && hw_set == '0) |=> $stable(status_q));

    assert_clear_exact_R4: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && !sw_load && hw_set == '0) |=>
        (status_q == ($past(status_q) & ~$past(sw_clr_mask))));

    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && (hw_set & sw_clr_mask) != '0) |=>
        ((status_q & $past(hw_set & sw_clr_mask)) == $past(hw_set & sw_clr_mask)));
endmodule

// File: rtl/errcap_capture.sv
module errcap_capture
    import errcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_ERR-1:0]  err_pulse,
    input  pkt_hdr_t          err_hdr,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              err_has_data,
    input  logic [DATA_W-1:0] err_data,
    input  logic              hdr_wr,
    input  cap_hdr_t          hdr_wval,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wval,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wval,
    output cap_hdr_t          cap_hdr,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    cap_hdr_t          cap_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [N_ERR-1:0]  elig;
    logic              hit, first, again;

    assign elig  = err_pulse & CAPTURE_MASK;
    assign hit   = |elig;
    assign first = hit && !cap_q.valid;
    assign again = hit && cap_q.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q.valid   <= 1'b0;
            cap_q.overrun <= 1'b0;
            cap_q.etype   <= '0;
        end else if (first) begin
            cap_q.valid   <= 1'b1;
            cap_q.overrun <= 1'b0;
            cap_q.etype   <= lowest_index(elig);
            cap_q.hdr     <= err_hdr;
        end else if (again) begin
            cap_q.overrun <= 1'b1;
        end else if (hdr_wr) begin
            cap_q <= hdr_wval;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && first) addr_q <= err_addr;
        else if (!rst && addr_wr) addr_q <= addr_wval;
    end

    always_ff @(posedge clk) begin
        if (!rst && first && err_has_data) data_q <= err_data;
        else if (!rst && data_wr) data_q <= data_wval;
    end

    assign cap_hdr  = cap_q;
    assign cap_addr = addr_q;
    assign cap_data = data_q;

    assert_first_capture_R7: assert property (@(posedge clk) disable iff (rst)
        first |=> (cap_q.valid && !cap_q.overrun && addr_q == $past(err_addr)
                   && cap_q.hdr == $past(err_hdr)));

    assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (rst)
        again |=> (cap_q.overrun && cap_q.valid));

    assert_drop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (err_pulse == DROP_ONLY && !hdr_wr) |=> $stable(cap_q));

    assert_data_needs_flit_R10: assert property (@(posedge clk) disable iff (rst)
        (!data_wr && !(first && err_has_data)) |=> $stable(data_q));
endmodule

// File: rtl/errcap_readmux.sv
module errcap_readmux
    import errcap_pkg::*;
(
    input  logic [RADDR_W-1:0] raddr,
    input  logic [N_ERR-1:0]   status,
    input  cap_hdr_t           cap_hdr,
    input  logic [ADDR_W-1:0]  cap_addr,
    input  logic [DATA_W-1:0]  cap_data,
    output logic [REG_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(raddr))
            REG_STATUS: rdata[N_ERR-1:0]  = status;
            REG_HDR:    rdata             = pack_hdr(cap_hdr);
            REG_ADDR:   rdata[ADDR_W-1:0] = cap_addr;
            REG_DATA:   rdata[DATA_W-1:0] = cap_data;
            default:    rdata             = '0;
        endcase
    end
endmodule

// File: rtl/errstat_capture.sv
module errstat_capture
    import errcap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [RADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [N_ERR-1:0]    err_pulse,
    input  logic [CMD_W-1:0]    err_cmd,
    input  logic [SUPPL_W-1:0]  err_suppl,
    input  logic [SRC_W-1:0]    err_src,
    input  logic [ADDR_W-1:0]   err_addr,
    input  logic                err_has_data,
    input  logic [DATA_W-1:0]   err_data,
    output logic                irq
);
    reg_sel_e          sel;
    logic              wr_status, wr_clear, wr_hdr, wr_addr, wr_data;
    logic [N_ERR-1:0]  status;
    pkt_hdr_t          in_hdr;
    cap_hdr_t          cap_hdr;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    assign sel       = reg_sel_e'(reg_addr);
    assign wr_status = reg_wr && sel == REG_STATUS;
    assign wr_clear  = reg_wr && sel == REG_CLEAR;
    assign wr_hdr    = reg_wr && sel == REG_HDR;
    assign wr_addr   = reg_wr && sel == REG_ADDR;
    assign wr_data   = reg_wr && sel == REG_DATA;

    assign in_hdr = '{cmd: err_cmd, suppl: err_suppl, src: err_src};

    errcap_status u_status (
        .clk         (clk),
        .rst         (rst),
        .hw_set      (err_pulse),
        .sw_load     (wr_status),
        .sw_load_val (reg_wdata[N_ERR-1:0]),
        .sw_clr      (wr_clear),
        .sw_clr_mask (reg_wdata[N_ERR-1:0]),
        .status      (status)
    );

    errcap_capture u_capture (
        .clk          (clk),
        .rst          (rst),
        .err_pulse    (err_pulse),
        .err_hdr      (in_hdr),
        .err_addr     (err_addr),
        .err_has_data (err_has_data),
        .err_data     (err_data),
        .hdr_wr       (wr_hdr),
        .hdr_wval     (unpack_hdr(reg_wdata)),
        .addr_wr      (wr_addr),
        .addr_wval    (reg_wdata[ADDR_W-1:0]),
        .data_wr      (wr_data),
        .data_wval    (reg_wdata[DATA_W-1:0]),
        .cap_hdr      (cap_hdr),
        .cap_addr     (cap_addr),
        .cap_data     (cap_data)
    );

    errcap_readmux u_rmux (
        .raddr    (reg_addr),
        .status   (status),
        .cap_hdr  (cap_hdr),
        .cap_addr (cap_addr),
        .cap_data (cap_data),
        .rdata    (reg_rdata)
    );

    assign irq = |status;

    assert_pulse_raises_irq_R3: assert property (@(posedge clk) disable iff (rst)
        (err_pulse != '0) |=> irq);

    assert_hdr_write_no_status_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_hdr && err_pulse == '0) |=> $stable(status));
endmodule

// File: tb/errstat_capture_test.sv
module errstat_capture_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [10:0] err_pulse = '0;
    logic [6:0]  err_cmd = '0;
    logic [10:0] err_suppl = '0;
    logic [10:0] err_src = '0;
    logic [37:0] err_addr = '0;
    logic        err_has_data = 1'b0;
    logic [63:0] err_data = '0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        bit          is_irq;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #10 clk = ~clk;

    errstat_capture uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_pulse(err_pulse),
        .err_cmd(err_cmd), .err_suppl(err_suppl), .err_src(err_src),
        .err_addr(err_addr), .err_has_data(err_has_data), .err_data(err_data),
        .irq(irq)
    );

    function automatic logic [63:0] mk_hdr(input logic v, input logic o, input logic [3:0] t,
                                           input logic [6:0] c, input logic [10:0] s,
                                           input logic [10:0] src);
        return {19'd0, v, 3'd0, o, 4'd0, t, 1'b0, src, 1'b0, s, 1'b0, c};
    endfunction

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {63'd0, irq} : reg_rdata;
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [63:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        ->chk_ev;
        #5;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1; it.exp = {63'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        ->chk_ev;
        #5;
    endtask

    task automatic set_pkt(input logic [6:0] c, input logic [10:0] s, input logic [10:0] src,
                           input logic [37:0] a, input logic hd, input logic [63:0] d);
        err_cmd = c; err_suppl = s; err_src = src; err_addr = a;
        err_has_data = hd; err_data = d;
    endtask

    task automatic pulse(input logic [10:0] bits);
        @(negedge clk);
        err_pulse = bits;
        @(negedge clk);
        err_pulse = '0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clear_and_pulse(input logic [10:0] m, input logic [10:0] bits);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = {53'd0, m}; err_pulse = bits;
        @(negedge clk);
        reg_wr = 1'b0; err_pulse = '0;
    endtask

    localparam logic [63:0] D1 = 64'hDEADBEEF_CAFEF00D;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_reg(3'd0, 64'h0, "R2 status zero after power-up");
        expect_irq(1'b0, "R3 irq low with no status");
        expect_reg(3'd2, 64'h0, "R12 header invalid after reset");

        set_pkt(7'h15, 11'h2AB, 11'h155, 38'h12_3456_789A, 1'b1, D1);
        pulse(11'h020);
        expect_reg(3'd0, 64'h020, "R1 reply-long sets bit 5");
        expect_reg(3'd0, 64'h020, "R2 read does not clear");
        expect_irq(1'b1, "R3 irq high");
        expect_reg(3'd2, mk_hdr(1, 0, 4'd5, 7'h15, 11'h2AB, 11'h155), "R7 R11 first header capture");
        expect_reg(3'd3, 64'h12_3456_789A, "R7 address capture");
        expect_reg(3'd4, D1, "R10 data capture with flit");

        set_pkt(7'h7F, 11'h001, 11'h7FE, 38'h3F_0000_0001, 1'b1, 64'h1111);
        pulse(11'h004);
        expect_reg(3'd0, 64'h024, "R1 request-short sets bit 2");
        expect_reg(3'd2, mk_hdr(1, 1, 4'd5, 7'h15, 11'h2AB, 11'h155), "R8 overrun set, fields kept");
        expect_reg(3'd4, D1, "R10 data kept while valid");

        pulse(11'h400);
        expect_reg(3'd0, 64'h424, "R1 clock drop sets bit 10");
        expect_reg(3'd2, mk_hdr(1, 1, 4'd5, 7'h15, 11'h2AB, 11'h155), "R9 clock drop leaves header");

        reg_write(3'd1, 64'h004);
        expect_reg(3'd0, 64'h420, "R4 clear only masked bit");
        expect_irq(1'b1, "R3 irq still high");

        clear_and_pulse(11'h420, 11'h020);
        expect_reg(3'd0, 64'h020, "R5 set wins over clear");

        reg_write(3'd1, 64'h7FF);
        expect_reg(3'd0, 64'h0, "R4 clear all");
        expect_irq(1'b0, "R3 irq low after clear");

        reg_write(3'd2, 64'h0);
        expect_reg(3'd2, 64'h0, "R11 header write clears valid");
        expect_reg(3'd0, 64'h0, "R11 header write sets no status");

        pulse(11'h400);
        expect_reg(3'd2, 64'h0, "R9 clock drop does not arm capture");
        expect_reg(3'd0, 64'h400, "R1 clock drop status");
        reg_write(3'd1, 64'h400);

        set_pkt(7'h7F, 11'h001, 11'h7FE, 38'h3F_0000_0001, 1'b0, 64'h2222);
        pulse(11'h200);
        expect_reg(3'd2, mk_hdr(1, 0, 4'd9, 7'h7F, 11'h001, 11'h7FE), "R7 capture type 9");
        expect_reg(3'd3, 64'h3F_0000_0001, "R7 address capture 2");
        expect_reg(3'd4, D1, "R10 no flit keeps data");

        reg_write(3'd0, 64'h003);
        expect_reg(3'd0, 64'h003, "R6 status load");
        expect_irq(1'b1, "R6 injected error raises irq");
        expect_reg(3'd2, mk_hdr(1, 0, 4'd9, 7'h7F, 11'h001, 11'h7FE), "R6 capture untouched");

        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        expect_reg(3'd0, 64'h003, "R2 status survives reset");
        expect_reg(3'd2, mk_hdr(0, 0, 4'd0, 7'h7F, 11'h001, 11'h7FE), "R12 reset clears flags");

        set_pkt(7'h01, 11'h400, 11'h003, 38'h00_0000_00AA, 1'b1, 64'h0123_4567_89AB_CDEF);
        pulse(11'h488);
        expect_reg(3'd0, 64'h48B, "R1 several bits at once");
        expect_reg(3'd2, mk_hdr(1, 0, 4'd3, 7'h01, 11'h400, 11'h003), "R7 lowest index wins");
        expect_reg(3'd4, 64'h0123_4567_89AB_CDEF, "R10 new flit captured");

        expect_reg(3'd1, 64'h0, "R12 clear register reads zero");
        reg_write(3'd3, 64'h25_5555_5555);
        expect_reg(3'd3, 64'h25_5555_5555, "R12 address write readback");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule